// File: doc/BRIEF.md
# Single-Slot Packet Timestamp Capture

This block records the value of the free-running time counter at the moment a selected event packet crosses the timestamp point of the receive path or of the transmit path. Each direction owns one capture slot, made of a low word, a high word and a valid flag. A capture fills the slot and locks it. While the slot is locked, later packets are not stamped. Software frees the slot by reading the high word of that direction.

Packet parsing happens upstream. The receive side is given a match strobe together with a packet class and a message type, and a programmable mode decides which of these strobes count. The transmit side counts every strobe. A strobe that would have captured but found its slot locked is dropped and counted in a saturating per-direction counter. Only reset clears that counter.

The read port is a plain register-style port with no back-pressure. `rd_data` shows the selected word in the same cycle. A read of a high word releases that slot on the next clock edge. Reads are never stalled and always complete in one cycle.

Top module: `tsc_capture`

## Requirements
- R1: A counted strobe into an empty, enabled slot stores `time_now` from the strobe cycle. The valid flag is seen on the following cycle, and the stored value reads back as low word (`rd_hi`=0) bits 31:0 and high word (`rd_hi`=1) bits 63:32.
- R2: While a slot is valid, further strobes leave its stored value unchanged.
- R3: A read cycle with `rd_en`=1 and `rd_hi`=1 clears the valid flag of the direction in `rd_dir` (0 = receive, 1 = transmit) on the next edge. The next counted strobe then captures again.
- R4: A low-word read (`rd_hi`=0) leaves the valid flag and the stored value untouched.
- R5: With the direction's enable low, strobes neither capture nor change the missed counter.
- R6: Receive `rx_class` encodes 0 = other, 1 = version-1 event over UDP, 2 = version-2 at layer 2, 3 = version-2 over UDP. Version-2 event messages have `rx_msg` 0 to 3. `rx_mode` selects what is counted: 0 = version-1 over UDP, 1 = version-2 events at layer 2 only, 2 = version-2 events at layer 2 or UDP, 3 = every strobe.
- R7: In mode 0, a strobe counts only if `rx_msg` equals 0 (Sync) when `v1_dreq`=0, or equals 1 (Delay_Req) when `v1_dreq`=1.
- R8: A counted, enabled strobe that finds its slot valid increments that direction's missed counter. The counter saturates at all ones and is cleared only by reset.
- R9: The two directions are independent. A strobe, read or release on one direction does not affect the other.
- R10: After reset, both valid flags and both missed counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | TIME_W | Current time counter value |
| rx_en | input | 1 | Receive capture enable |
| rx_match | input | 1 | Receive packet strobe from the parser |
| rx_class | input | 2 | Receive packet class (R6) |
| rx_msg | input | 4 | Receive message type |
| rx_mode | input | 2 | Receive selection mode (R6) |
| v1_dreq | input | 1 | Version-1 message select: 0 Sync, 1 Delay_Req |
| tx_en | input | 1 | Transmit capture enable |
| tx_match | input | 1 | Transmit packet strobe |
| rd_en | input | 1 | Read strobe |
| rd_dir | input | 1 | Read direction: 0 receive, 1 transmit |
| rd_hi | input | 1 | Word select: 0 low, 1 high (releases slot) |
| rd_data | output | TIME_W/2 | Selected capture word, combinational |
| rx_valid | output | 1 | Receive slot holds a timestamp |
| tx_valid | output | 1 | Transmit slot holds a timestamp |
| rx_miss | output | MISS_W | Receive dropped-capture count |
| tx_miss | output | MISS_W | Transmit dropped-capture count |

## Verification
The properties take the strobes, class, message, mode and select inputs to be known and constant across each clock edge. They also take `time_now` to be a plain input that the block never feeds back. The bench drives every input at the falling edge and advances `time_now` in steps of 8 from a value just below a 32-bit carry, so captures near the carry check the word split. It sweeps every combination of mode, version-1 select, class and message, and releases the slot after each capture so that the filter is judged alone. The lock, miss-count and saturation cases then run on the transmit side.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int NUM_DIRS = 2;
  localparam int DIR_RX   = 0;
  localparam int DIR_TX   = 1;

  typedef enum logic [1:0] {
    RXM_V1_UDP = 2'd0,
    RXM_V2_L2  = 2'd1,
    RXM_V2_ANY = 2'd2,
    RXM_ALL    = 2'd3
  } rx_mode_e;

  typedef enum logic [1:0] {
    PC_OTHER  = 2'd0,
    PC_V1_UDP = 2'd1,
    PC_V2_L2  = 2'd2,
    PC_V2_UDP = 2'd3
  } pkt_class_e;

  localparam logic [3:0] V2_EVENT_LAST = 4'd3;
endpackage

// File: rtl/tsc_rx_filter.sv
module tsc_rx_filter
  import tsc_pkg::*;
(
  input  logic       strobe,
  input  logic [1:0] mode,
  input  logic [1:0] cls,
  input  logic [3:0] msg,
  input  logic       v1_dreq,
  output logic       hit
);
  logic v2_event;
  logic v1_sel;
  pkt_class_e cls_e;

  assign cls_e    = pkt_class_e'(cls);
  assign v2_event = (msg <= V2_EVENT_LAST);
  assign v1_sel   = (msg == {3'b000, v1_dreq});

  always_comb begin
    hit = 1'b0;
    unique case (rx_mode_e'(mode))
      RXM_V1_UDP: hit = (cls_e == PC_V1_UDP) && v1_sel;
      RXM_V2_L2:  hit = (cls_e == PC_V2_L2) && v2_event;
      RXM_V2_ANY: hit = ((cls_e == PC_V2_L2) || (cls_e == PC_V2_UDP)) && v2_event;
      RXM_ALL:    hit = 1'b1;
      default:    hit = 1'b0;
    endcase
    hit = hit && strobe;
  end
endmodule

// File: rtl/tsc_slot.sv
module tsc_slot #(
  parameter int TIME_W = 64,
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              strobe,
  input  logic              release_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              valid,
  output logic [TIME_W-1:0] stamp,
  output logic [MISS_W-1:0] miss
);
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  logic take;
  logic drop;

  assign take = en && strobe && !valid;
  assign drop = en && strobe && valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      stamp <= '0;
    end else if (take) begin
      valid <= 1'b1;
      stamp <= time_i;
    end else if (release_i) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss <= '0;
    end else if (drop && (miss != MISS_MAX)) begin
      miss <= miss + 1'b1;
    end
  end
endmodule

// File: rtl/tsc_read_port.sv
module tsc_read_port
  import tsc_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic                             rd_en,
  input  logic                             rd_dir,
  input  logic                             rd_hi,
  input  logic [NUM_DIRS-1:0][TIME_W-1:0]  stamps,
  output logic [TIME_W/2-1:0]              rd_data,
  output logic [NUM_DIRS-1:0]              release_o
);
  localparam int WORD_W = TIME_W / 2;

  logic [TIME_W-1:0] sel_stamp;

  assign sel_stamp = stamps[rd_dir];
  assign rd_data   = rd_hi ? sel_stamp[TIME_W-1:WORD_W] : sel_stamp[WORD_W-1:0];

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_rel
    assign release_o[d] = rd_en && rd_hi && (int'(rd_dir) == d);
  end
endmodule

// File: rtl/tsc_capture.sv
module tsc_capture
  import tsc_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int MISS_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TIME_W-1:0]   time_now,
  input  logic                rx_en,
  input  logic                rx_match,
  input  logic [1:0]          rx_class,
  input  logic [3:0]          rx_msg,
  input  logic [1:0]          rx_mode,
  input  logic                v1_dreq,
  input  logic                tx_en,
  input  logic                tx_match,
  input  logic                rd_en,
  input  logic                rd_dir,
  input  logic                rd_hi,
  output logic [TIME_W/2-1:0] rd_data,
  output logic                rx_valid,
  output logic                tx_valid,
  output logic [MISS_W-1:0]   rx_miss,
  output logic [MISS_W-1:0]   tx_miss
);
  logic                            rx_hit;
  logic [NUM_DIRS-1:0]             en_v;
  logic [NUM_DIRS-1:0]             strobe_v;
  logic [NUM_DIRS-1:0]             release_v;
  logic [NUM_DIRS-1:0]             valid_v;
  logic [NUM_DIRS-1:0][TIME_W-1:0] stamp_q;
  logic [NUM_DIRS-1:0][MISS_W-1:0] miss_v;

  tsc_rx_filter u_filter (
    .strobe  (rx_match),
    .mode    (rx_mode),
    .cls     (rx_class),
    .msg     (rx_msg),
    .v1_dreq (v1_dreq),
    .hit     (rx_hit)
  );

  assign en_v[DIR_RX]     = rx_en;
  assign en_v[DIR_TX]     = tx_en;
  assign strobe_v[DIR_RX] = rx_hit;
  assign strobe_v[DIR_TX] = tx_match;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_slot
    tsc_slot #(.TIME_W(TIME_W), .MISS_W(MISS_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_v[d]),
      .strobe    (strobe_v[d]),
      .release_i (release_v[d]),
      .time_i    (time_now),
      .valid     (valid_v[d]),
      .stamp     (stamp_q[d]),
      .miss      (miss_v[d])
    );
  end

  tsc_read_port #(.TIME_W(TIME_W)) u_rd (
    .rd_en     (rd_en),
    .rd_dir    (rd_dir),
    .rd_hi     (rd_hi),
    .stamps    (stamp_q),
    .rd_data   (rd_data),
    .release_o (release_v)
  );

  assign rx_valid = valid_v[DIR_RX];
  assign tx_valid = valid_v[DIR_TX];
  assign rx_miss  = miss_v[DIR_RX];
  assign tx_miss  = miss_v[DIR_TX];
endmodule

// File: rtl/tsc_capture_chk.sv
module tsc_capture_chk #(
  parameter int TIME_W = 64,
  parameter int MISS_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [TIME_W-1:0]       time_now,
  input logic                    rx_en,
  input logic                    rx_hit,
  input logic                    tx_en,
  input logic                    tx_match,
  input logic                    rd_en,
  input logic                    rd_dir,
  input logic                    rd_hi,
  input logic                    rx_valid,
  input logic                    tx_valid,
  input logic [MISS_W-1:0]       tx_miss,
  input logic [1:0][TIME_W-1:0]  stamp_q
);
  localparam logic [MISS_W-1:0] MISS_MAX = '1;
  localparam logic [MISS_W-1:0] ONE      = {{(MISS_W-1){1'b0}}, 1'b1};

  // R1
  tx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_match && !tx_valid) |=> (tx_valid && stamp_q[1] == $past(time_now)));

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !(rd_en && rd_dir && rd_hi)) |=> (tx_valid && $stable(stamp_q[1])));

  // R3
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_dir && rd_hi) |=> !tx_valid);

  // R4
  lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rd_en && !rd_hi) |=> rx_valid);

  // R5
  tx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !tx_valid) |=> (!tx_valid && $stable(tx_miss)));

  // R6
  rx_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(rx_hit && rx_en));

  // R8
  tx_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_match && tx_valid && tx_miss != MISS_MAX) |=> (tx_miss == $past(tx_miss) + ONE));
endmodule

bind tsc_capture tsc_capture_chk #(.TIME_W(TIME_W), .MISS_W(MISS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .time_now (time_now),
  .rx_en    (rx_en),
  .rx_hit   (rx_hit),
  .tx_en    (tx_en),
  .tx_match (tx_match),
  .rd_en    (rd_en),
  .rd_dir   (rd_dir),
  .rd_hi    (rd_hi),
  .rx_valid (rx_valid),
  .tx_valid (tx_valid),
  .tx_miss  (tx_miss),
  .stamp_q  (stamp_q)
);

// File: tb/test_tsc_capture.sv
module test_tsc_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = 64'h0000_00FF_FFFF_FF00;
  logic        rx_en = 1'b0, rx_match = 1'b0, v1_dreq = 1'b0;
  logic [1:0]  rx_class = 2'd0, rx_mode = 2'd0;
  logic [3:0]  rx_msg = 4'd0;
  logic        tx_en = 1'b0, tx_match = 1'b0;
  logic        rd_en = 1'b0, rd_dir = 1'b0, rd_hi = 1'b0;
  logic [31:0] rd_data;
  logic        rx_valid, tx_valid;
  logic [7:0]  rx_miss, tx_miss;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) time_now <= time_now + 64'd8;

  tsc_capture i_tsc_capture (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .rx_en(rx_en), .rx_match(rx_match), .rx_class(rx_class), .rx_msg(rx_msg),
    .rx_mode(rx_mode), .v1_dreq(v1_dreq), .tx_en(tx_en), .tx_match(tx_match),
    .rd_en(rd_en), .rd_dir(rd_dir), .rd_hi(rd_hi), .rd_data(rd_data),
    .rx_valid(rx_valid), .tx_valid(tx_valid), .rx_miss(rx_miss), .tx_miss(tx_miss)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input bit dir, input bit hi, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_dir = dir; rd_hi = hi;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rx_pulse(input logic [1:0] c, input logic [3:0] m, output logic [63:0] t);
    @(negedge clk);
    rx_match = 1'b1; rx_class = c; rx_msg = m; t = time_now;
    @(negedge clk);
    rx_match = 1'b0;
  endtask

  task automatic tx_pulse(input int cnt, output logic [63:0] t);
    @(negedge clk);
    tx_match = 1'b1; t = time_now;
    repeat (cnt) @(negedge clk);
    tx_match = 1'b0;
  endtask

  function automatic bit rx_expect(input int mode, input int dq, input int c, input int m);
    case (mode)
      0: return (c == 1) && (m == dq);
      1: return (c == 2) && (m <= 3);
      2: return (c == 2 || c == 3) && (m <= 3);
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] t, t2;
    logic [31:0] w;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!rx_valid && !tx_valid, "R10 valid after reset", {rx_valid, tx_valid}, 0);
    chk(rx_miss == 0 && tx_miss == 0, "R10 miss after reset", {rx_miss, tx_miss}, 0);

    // R6 R7 R1 R3 sweep of the receive filter
    rx_en = 1'b1;
    for (int md = 0; md < 4; md++)
      for (int dq = 0; dq < 2; dq++)
        for (int c = 0; c < 4; c++)
          for (int m = 0; m < 16; m++) begin
            bit e;
            rx_mode = 2'(md); v1_dreq = dq[0];
            e = rx_expect(md, dq, c, m);
            rx_pulse(2'(c), 4'(m), t);
            chk(rx_valid == e, (md == 0) ? "R7 rx select" : "R6 rx select", 64'(rx_valid), 64'(e));
            if (e) begin
              rd(1'b0, 1'b0, w);
              chk(w == t[31:0], "R1 low word", 64'(w), 64'(t[31:0]));
              chk(rx_valid, "R4 low read keeps slot", 64'(rx_valid), 1);
              rd(1'b0, 1'b1, w);
              chk(w == t[63:32], "R1 high word", 64'(w), 64'(t[63:32]));
              chk(!rx_valid, "R3 high read releases", 64'(rx_valid), 0);
            end
          end
    chk(rx_miss == 0, "R8 no receive drops", 64'(rx_miss), 0);

    // R2 R4 R8 lock on transmit
    tx_en = 1'b1;
    tx_pulse(1, t);
    chk(tx_valid, "R1 tx capture", 64'(tx_valid), 1);
    tx_pulse(2, t2);
    rd(1'b1, 1'b0, w);
    chk(w == t[31:0], "R2 locked low word", 64'(w), 64'(t[31:0]));
    chk(tx_valid, "R4 tx low read keeps slot", 64'(tx_valid), 1);
    chk(tx_miss == 2, "R8 two drops", 64'(tx_miss), 2);
    rd(1'b1, 1'b1, w);
    chk(w == t[63:32], "R2 locked high word", 64'(w), 64'(t[63:32]));
    chk(!tx_valid, "R3 tx release", 64'(tx_valid), 0);
    tx_pulse(1, t);
    rd(1'b1, 1'b0, w);
    chk(w == t[31:0], "R3 recapture low", 64'(w), 64'(t[31:0]));

    // R5 disabled: locked slot, strobes do not count
    tx_en = 1'b0;
    tx_pulse(3, t2);
    chk(tx_miss == 2, "R5 disabled no miss", 64'(tx_miss), 2);
    rd(1'b1, 1'b1, w);
    chk(w == t[63:32], "R5 slot untouched", 64'(w), 64'(t[63:32]));
    tx_pulse(2, t2);
    chk(!tx_valid, "R5 disabled no capture", 64'(tx_valid), 0);

    // R9 independence
    tx_en = 1'b1; rx_mode = 2'd3;
    tx_pulse(1, t);
    rx_pulse(2'd0, 4'd9, t2);
    rd(1'b1, 1'b1, w);
    chk(w == t[63:32], "R9 tx high", 64'(w), 64'(t[63:32]));
    chk(rx_valid && !tx_valid, "R9 rx kept", {rx_valid, tx_valid}, 2);
    rd(1'b0, 1'b0, w);
    chk(w == t2[31:0], "R9 rx low", 64'(w), 64'(t2[31:0]));
    chk(rx_miss == 0, "R9 rx miss unaffected", 64'(rx_miss), 0);
    rd(1'b0, 1'b1, w);

    // R8 saturation
    base = int'(tx_miss);
    tx_pulse(1, t);
    tx_pulse(300, t2);
    chk(tx_miss == 8'hFF, "R8 saturate", 64'(tx_miss), (base + 300 > 255) ? 255 : base + 300);
    rd(1'b1, 1'b0, w);
    chk(w == t[31:0], "R2 held through drops", 64'(w), 64'(t[31:0]));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule